// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Unit

This block watches a port of general-purpose input pins and turns their edges into interrupt requests. Each pin carries a polarity bit that arms it for either a rising or a falling edge. A detected edge latches a status bit. The port interrupt line stays high while any latched status bit is also enabled. Software, or a small sequencer, reads a pending-pin index and acknowledges the request. The index always names the highest-numbered pin that is pending and enabled, and the acknowledge clears that pin's status bit.

To report both edges with single-edge detectors, a pin can be placed in dual-edge mode. When this mode is armed, the pin's polarity comes from its present level: a high pin is armed for a falling edge and a low pin for a rising edge. The pin is also recorded in a dual-edge mask. Each acknowledge of a masked pin inverts its polarity in the same cycle as the status clear, so the next opposite transition is caught. As long as every event is acknowledged before the pin moves again, every transition of the pin is reported.

Configuration goes through a single write port with an operation code. The operations are: write the polarity, set polarity bits, clear polarity bits, write the enable, clear status bits, arm dual-edge mode, and drop dual-edge mode. All configuration state is visible on output ports.

Top module: `gpio_dual_edge_irq`

## Requirements
- R1: After reset the polarity, dual-edge mask, enable and status are all zero, and irq_o and pend_valid_o are low.
- R2: The pin's previous level is registered once per clock. With polarity bit 0 a low-to-high change sets that pin's status bit at the next edge; with polarity bit 1 a high-to-low change does. Changes in the other direction set nothing.
- R3: Status bits latch whatever the enable is. irq_o is high exactly when status AND enable is nonzero.
- R4: With wr_en_i high, op 0 loads polarity from wr_data_i, op 1 ORs wr_data_i into polarity, and op 2 clears the polarity bits set in wr_data_i. Each takes effect at the next edge.
- R5: Op 5 sets the dual-edge mask bits given in wr_data_i. It also loads each of those pins' polarity with its current pin_i level (1 means falling) and leaves the other pins alone.
- R6: Op 6 clears the dual-edge mask bits given in wr_data_i and leaves polarity unchanged. Later acknowledges of those pins no longer flip polarity.
- R7: pend_valid_o is high when status AND enable is nonzero. pend_idx_o is then the highest index among those bits.
- R8: ack_i with pend_valid_o high clears the status bit at pend_idx_o at the next edge. If that pin is in the dual-edge mask, its polarity (after any same-cycle write) is inverted at that edge. An edge detected in the same cycle still sets the status bit.
- R9: A dual-edge pin whose events are each acknowledged reports a rise, a fall and a rise again, in that order.
- R10: Op 4 clears the status bits given in wr_data_i. Op 3 loads the enable. Op 7 changes nothing.
- R11: ack_i while pend_valid_o is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Pin levels, synchronous to clk |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_op_i | input | 3 | Write operation code (0..7) |
| wr_data_i | input | NPINS | Write data / pin mask |
| ack_i | input | 1 | Acknowledge of the pending pin |
| irq_o | output | 1 | Port interrupt request |
| pend_valid_o | output | 1 | A pending enabled pin exists |
| pend_idx_o | output | $clog2(NPINS) | Highest pending enabled pin |
| pol_o | output | NPINS | Polarity (1 = falling edge) |
| both_o | output | NPINS | Dual-edge mask |
| en_o | output | NPINS | Enable |
| stat_o | output | NPINS | Latched status |

## Verification
A polarity bit that is wrong for a dual-edge pin shows up at the port as soon as that pin next changes level. The expected edge produces no status bit, or an unexpected one appears, one clock after the pin change. A wrong priority choice or a missed status clear shows up at once on pend_idx_o and irq_o, in the cycle after the acknowledge. The bench therefore compares every register output and the pending index against its own model after every clock. This catches a divergence within one cycle of its cause.

// File: rtl/gpio_dei_pkg.sv
package gpio_dei_pkg;

  typedef enum logic [2:0] {
    OP_POL_WR    = 3'd0,
    OP_POL_SET   = 3'd1,
    OP_POL_CLR   = 3'd2,
    OP_EN_WR     = 3'd3,
    OP_STAT_CLR  = 3'd4,
    OP_ARM_BOTH  = 3'd5,
    OP_DROP_BOTH = 3'd6,
    OP_NOP       = 3'd7
  } op_e;

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] hit_o
);

  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_i;
  end

  // One single-edge detector per pin; polarity picks the direction.
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall;
    assign rise     = pin_i[g] & ~pin_q[g];
    assign fall     = ~pin_i[g] & pin_q[g];
    assign hit_o[g] = pol_i[g] ? fall : rise;
  end

endmodule

// File: rtl/gpio_pend_select.sv
module gpio_pend_select #(
  parameter int NPINS = 32,
  localparam int IW = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] req_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o
);

  function automatic logic [IW-1:0] top_index(input logic [NPINS-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NPINS; i++)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign valid_o = |req_i;
  assign idx_o   = top_index(req_i);

endmodule

// File: rtl/gpio_dual_edge_irq.sv
module gpio_dual_edge_irq
  import gpio_dei_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int IW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_op_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             pend_valid_o,
  output logic [IW-1:0]    pend_idx_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] both_o,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] stat_o
);

  logic [NPINS-1:0] pol_q, both_q, en_q, stat_q;
  logic [NPINS-1:0] hit_vec, active;
  logic [NPINS-1:0] pol_wr, both_wr, en_wr, wr_clr;
  logic [NPINS-1:0] ack_mask, flip_set, flip_clr;
  logic             ack_fire;

  gpio_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .pol_i (pol_q),
    .hit_o (hit_vec)
  );

  assign active = stat_q & en_q;

  gpio_pend_select #(.NPINS(NPINS)) u_pend (
    .req_i   (active),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

  // Configuration writes
  always_comb begin
    pol_wr  = pol_q;
    both_wr = both_q;
    en_wr   = en_q;
    wr_clr  = '0;
    if (wr_en_i) begin
      case (op_e'(wr_op_i))
        OP_POL_WR:    pol_wr  = wr_data_i;
        OP_POL_SET:   pol_wr  = pol_q | wr_data_i;
        OP_POL_CLR:   pol_wr  = pol_q & ~wr_data_i;
        OP_EN_WR:     en_wr   = wr_data_i;
        OP_STAT_CLR:  wr_clr  = wr_data_i;
        OP_ARM_BOTH: begin
          both_wr = both_q | wr_data_i;
          pol_wr  = (pol_q & ~wr_data_i) | (pin_i & wr_data_i);
        end
        OP_DROP_BOTH: both_wr = both_q & ~wr_data_i;
        default: ;
      endcase
    end
  end

  // Acknowledge: clear status, flip dual-edge polarity through set/clear masks
  assign ack_fire = ack_i & pend_valid_o;
  assign ack_mask = ack_fire ? (NPINS'(1) << pend_idx_o) : '0;
  assign flip_set = ack_mask & both_q & ~pol_wr;
  assign flip_clr = ack_mask & both_q & pol_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      both_q <= '0;
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      pol_q  <= (pol_wr | flip_set) & ~flip_clr;
      both_q <= both_wr;
      en_q   <= en_wr;
      stat_q <= (stat_q & ~(wr_clr | ack_mask)) | hit_vec;
    end
  end

  assign irq_o  = |active;
  assign pol_o  = pol_q;
  assign both_o = both_q;
  assign en_o   = en_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/gpio_dual_edge_irq_chk.sv
module gpio_dual_edge_irq_chk #(
  parameter int NPINS = 32,
  localparam int IW = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [2:0]       wr_op_i,
  input logic [NPINS-1:0] wr_data_i,
  input logic             irq_o,
  input logic             pend_valid_o,
  input logic [IW-1:0]    pend_idx_o,
  input logic [NPINS-1:0] pol_o,
  input logic [NPINS-1:0] both_o,
  input logic [NPINS-1:0] en_o,
  input logic [NPINS-1:0] stat_o,
  input logic [NPINS-1:0] hit_vec,
  input logic             ack_fire
);

  AST_IRQ_PEND_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == pend_valid_o); // R3

  AST_PEND_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (stat_o[pend_idx_o] && en_o[pend_idx_o])); // R7

  AST_PEND_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (((stat_o & en_o) >> pend_idx_o) == NPINS'(1))); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (!stat_o[$past(pend_idx_o)] || $past(hit_vec[pend_idx_o]))); // R8

  AST_ACK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && both_o[pend_idx_o] && !wr_en_i)
      |=> (pol_o[$past(pend_idx_o)] != $past(pol_o[pend_idx_o]))); // R8

  AST_POL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_op_i == 3'd1 && !ack_fire)
      |=> ((pol_o & $past(wr_data_i)) == $past(wr_data_i))); // R4

  AST_IDLE_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_valid_o && !wr_en_i) |=> $stable(pol_o) && $stable(both_o)); // R11

endmodule

bind gpio_dual_edge_irq gpio_dual_edge_irq_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/gpio_dual_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_dual_edge_irq_test;
  localparam int N  = 32;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_i = '0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_op_i = '0;
  logic [N-1:0]  wr_data_i = '0;
  logic          ack_i = 1'b0;
  logic          irq_o, pend_valid_o;
  logic [IW-1:0] pend_idx_o;
  logic [N-1:0]  pol_o, both_o, en_o, stat_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic [N-1:0] m_pol = '0, m_both = '0, m_en = '0, m_stat = '0, m_prev = '0;

  always #10 clk = ~clk;

  gpio_dual_edge_irq #(.NPINS(N)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_top(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_step(input logic [N-1:0] p, input logic we,
                            input logic [2:0] op, input logic [N-1:0] d,
                            input logic ak);
    logic [N-1:0] hit, np, nb, ne, clr;
    int top;
    hit = ((p & ~m_prev) & ~m_pol) | ((~p & m_prev) & m_pol);
    np = m_pol; nb = m_both; ne = m_en; clr = '0;
    if (we) begin
      case (op)
        3'd0: np = d;
        3'd1: np = np | d;
        3'd2: np = np & ~d;
        3'd3: ne = d;
        3'd4: clr = d;
        3'd5: begin nb = nb | d; np = (np & ~d) | (p & d); end
        3'd6: nb = nb & ~d;
        default: ;
      endcase
    end
    top = model_top(m_stat & m_en);
    if (ak && top >= 0) begin
      clr[top] = 1'b1;
      if (m_both[top]) np[top] = ~np[top];
    end
    m_stat = (m_stat & ~clr) | hit;
    m_pol = np; m_both = nb; m_en = ne; m_prev = p;
  endtask

  task automatic compare_all(input string tag);
    int top;
    top = model_top(m_stat & m_en);
    chk({tag, " stat"}, 64'(stat_o), 64'(m_stat));
    chk({tag, " pol"},  64'(pol_o),  64'(m_pol));
    chk({tag, " both"}, 64'(both_o), 64'(m_both));
    chk({tag, " en"},   64'(en_o),   64'(m_en));
    chk({tag, " irq"},  64'(irq_o),  64'(top >= 0));
    chk({tag, " pv"},   64'(pend_valid_o), 64'(top >= 0));
    if (top >= 0) chk({tag, " idx"}, 64'(pend_idx_o), 64'(top));
  endtask

  // Called at a negedge: drive, model, clock, compare at the next negedge.
  task automatic step(input string tag, input logic [N-1:0] p, input logic we,
                      input logic [2:0] op, input logic [N-1:0] d, input logic ak);
    pin_i = p; wr_en_i = we; wr_op_i = op; wr_data_i = d; ack_i = ak;
    model_step(p, we, op, d, ak);
    @(posedge clk);
    @(negedge clk);
    pin_i = p; wr_en_i = 1'b0; ack_i = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pins;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all("R1");
    chk("R1 stat", 64'(stat_o), 0);
    chk("R1 irq", 64'(irq_o), 0);

    step("R10 en write", '0, 1, 3'd3, '1, 0);
    pins = 32'h0000_0008;
    step("R2 rise", pins, 0, 3'd0, '0, 0);
    chk("R2 stat bit3", 64'(stat_o), 64'h8);
    chk("R7 idx3", 64'(pend_idx_o), 3);
    pins = 32'h0000_002A;
    step("R7 multi", pins, 0, 3'd0, '0, 0);
    chk("R7 idx5", 64'(pend_idx_o), 5);
    step("R8 ack", pins, 0, 3'd0, '0, 1);
    chk("R8 stat", 64'(stat_o), 64'h0A);
    chk("R8 idx3", 64'(pend_idx_o), 3);
    step("R10 w1c", pins, 1, 3'd4, 32'h0A, 0);
    chk("R10 irq low", 64'(irq_o), 0);
    step("R11 idle ack", pins, 0, 3'd0, '0, 1);
    chk("R11 stat", 64'(stat_o), 0);
    step("R4 set", pins, 1, 3'd1, 32'h1, 0);
    chk("R4 pol", 64'(pol_o), 1);
    step("R3 en off", pins, 1, 3'd3, '0, 0);
    pins = 32'h0000_0002;
    step("R2 fall ignored", pins, 0, 3'd0, '0, 0);
    chk("R2 no fall hit", 64'(stat_o), 0);
    pins = 32'h0000_0042;
    step("R3 latch masked", pins, 0, 3'd0, '0, 0);
    chk("R3 stat", 64'(stat_o), 64'h40);
    chk("R3 irq low", 64'(irq_o), 0);
    step("R10 w1c", pins, 1, 3'd4, 32'h40, 0);
    step("R5 arm", pins, 1, 3'd5, 32'hC0, 0);
    chk("R5 pol", 64'(pol_o), 64'h41);
    chk("R5 both", 64'(both_o), 64'hC0);
    step("R10 en", pins, 1, 3'd3, '1, 0);
    // R9 dual-edge sequence on pin 7
    pins = pins | 32'h80;
    step("R9 rise", pins, 0, 3'd0, '0, 0);
    chk("R9 rise seen", 64'(stat_o[7]), 1);
    step("R9 ack1", pins, 0, 3'd0, '0, 1);
    chk("R8 flip to fall", 64'(pol_o[7]), 1);
    pins = pins & ~32'h80;
    step("R9 fall", pins, 0, 3'd0, '0, 0);
    chk("R9 fall seen", 64'(stat_o[7]), 1);
    step("R9 ack2", pins, 0, 3'd0, '0, 1);
    chk("R9 flip to rise", 64'(pol_o[7]), 0);
    pins = pins | 32'h80;
    step("R9 rise2", pins, 0, 3'd0, '0, 0);
    chk("R9 rise2 seen", 64'(stat_o[7]), 1);
    step("R6 drop", pins, 1, 3'd6, 32'h80, 0);
    chk("R6 both", 64'(both_o), 64'h40);
    chk("R6 pol kept", 64'(pol_o[7]), 0);
    step("R6 ack no flip", pins, 0, 3'd0, '0, 1);
    chk("R6 pol7", 64'(pol_o[7]), 0);
    step("R10 nop", pins, 1, 3'd7, '1, 0);
    step("R4 clr", pins, 1, 3'd2, 32'h1, 0);
    chk("R4 pol clr", 64'(pol_o[0]), 0);
    step("R4 write", pins, 1, 3'd0, 32'h0F0F_0000, 0);
    chk("R4 pol wr", 64'(pol_o), 64'h0F0F_0000);

    // Constrained random phase
    for (int k = 0; k < 3000; k++) begin
      logic we, ak;
      logic [2:0] op;
      logic [N-1:0] d;
      pins = pins ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 5) == 0;
      op = 3'($urandom % 8);
      d  = (op == 3'd3) ? ($urandom | $urandom) : ($urandom & $urandom);
      ak = ($urandom % 3) == 0;
      step("R2/R8 random", pins, we, op, d, ak);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule